// File: doc/BRIEF.md
# Flash Command and Lock Controller

This block sits between a register bus and an on-chip flash array and runs one command at a time. Software writes a 32-bit command word holding a protection key, an opcode and a 16-bit argument. Four commands exist: a page write that erases one page and fills it with a staged data word, lock-set and lock-clear for the region holding a given page, and a lock query that rewinds a read pointer over the lock bits. Each lock bit protects a group of consecutive pages. A page write aimed at a protected group is refused as a whole.

A status byte reports readiness, a completion event and three sticky error flags. Reading the status clears the event and the error flags. When the interrupt enable in the mode register is set, the completion event drives an interrupt output. The lock bits are streamed out 32 at a time through a result port. Each read advances to the next word, and reads past the last word return zero. A small behavioural flash array inside the block models the storage, the busy time of a page write and an injectable verify failure. Its read port is blocked only while a page write is running.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command word whose key byte (bits 31:24) is not 8'hA5 sets the command-error flag (status bit 2). It is not executed: the lock bits and the array stay unchanged, and ready stays high.
- R2: Status bit 0 (ready) drops in the cycle after a command is accepted. It stays low for PROG_CYCLES cycles for a page write and LOCK_CYCLES cycles for a lock command, then returns high. A command written while ready is low is ignored.
- R3: When any accepted command completes, the done event (status bit 1) is set. The irq output equals the done event ANDed with the interrupt enable, which is loaded from mode_irq_en on a mode_wr pulse.
- R4: Opcode 8'h08 sets, and opcode 8'h09 clears, the lock bit of region arg/PAGES_PER_REGION (arg is bits 23:8) when the command completes. No other command changes any lock bit.
- R5: With a good key, an unknown opcode, a lock-set or lock-clear whose region is NUM_REGIONS or more, or a page write whose page is NUM_PAGES or more sets the command-error flag. Nothing else changes.
- R6: A page write (opcode 8'h03) to a page in a locked region sets the lock-error flag (status bit 3). No page is written, and ready stays high.
- R7: An accepted page write stores the wbuf value captured at acceptance into the addressed page when it completes. All pages read 32'hFFFFFFFF after reset.
- R8: The lock query (opcode 8'h0A) ignores its argument and resets the result pointer to word 0 on acceptance. res_word shows word k, whose bit n is the lock bit of region 32k+n. Each res_rd pulse advances k, and words at or beyond ceil(NUM_REGIONS/32) read zero.
- R9: If vfy_fail is high in the cycle an accepted command completes, the flash-error flag (status bit 4) is set.
- R10: fl_rvalid is low only while a page write is in progress. Array reads stay valid during lock commands.
- R11: A stat_rd pulse clears the done event and the three error flags at the next edge. An event arriving in the same cycle wins.
- R12: After reset all regions are unlocked, the status byte reads 8'h01, irq is low and the result pointer is at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | 32 | Key [31:24], argument [23:8], opcode [7:0] |
| wbuf | input | 32 | Data staged for a page write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_irq_en | input | 1 | Interrupt enable written on mode_wr |
| stat_rd | input | 1 | Status read strobe (read-to-clear) |
| stat_word | output | 8 | {3'b0, flash_err, lock_err, cmd_err, done, ready} |
| res_rd | input | 1 | Result register read strobe |
| res_word | output | 32 | Current lock-bit word |
| vfy_fail | input | 1 | Injected verify failure |
| fl_raddr | input | PAW | Array read address |
| fl_rdata | output | 32 | Array read data |
| fl_rvalid | output | 1 | Array read permitted |
| irq | output | 1 | Completion interrupt |

## Verification
A corrupted lock bit surfaces in one of two ways. The next lock query returns the wrong res_word, or a later page write to that region succeeds or fails wrongly, which shows in status bit 3 at the cycle after the write. A stuck busy timer shows as ready staying low past its fixed window, and a missed pointer rewind shows in the first result read after a query. The reference model compares every output each cycle, so any such divergence is flagged on the first cycle it reaches a port.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam logic [7:0] CMD_KEY = 8'hA5;
  localparam logic [7:0] OPC_PAGE_WRITE = 8'h03;
  localparam logic [7:0] OPC_LOCK_SET   = 8'h08;
  localparam logic [7:0] OPC_LOCK_CLR   = 8'h09;
  localparam logic [7:0] OPC_LOCK_QUERY = 8'h0A;

  typedef enum logic [2:0] {K_NONE, K_PWRITE, K_LSET, K_LCLR, K_LQUERY} cmd_kind_e;

  // region that holds a given page
  function automatic int region_of(int page, int pages_per_region);
    return page / pages_per_region;
  endfunction

  // number of 32-bit words needed to carry n lock bits
  function automatic int words_for(int n);
    return (n + 31) / 32;
  endfunction
endpackage

// File: rtl/fcl_decode.sv
module fcl_decode
  import fcl_pkg::*;
#(
  parameter int NUM_PAGES = 80,
  parameter int PAGES_PER_REGION = 2,
  parameter int NUM_REGIONS = 40,
  localparam int RW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [31:0]            cmd,
  input  logic [NUM_REGIONS-1:0] lock_bits,
  output cmd_kind_e              kind,
  output logic                   bad_cmd,
  output logic                   locked_hit
);
  logic [15:0]   arg;
  logic [7:0]    opc;
  int            region;
  logic [RW-1:0] ridx;

  assign arg    = cmd[23:8];
  assign opc    = cmd[7:0];
  assign region = region_of(int'(arg), PAGES_PER_REGION);
  assign ridx   = RW'(region);

  always_comb begin
    kind       = K_NONE;
    bad_cmd    = 1'b0;
    locked_hit = 1'b0;
    if (cmd[31:24] != CMD_KEY) begin
      bad_cmd = 1'b1;
    end else begin
      case (opc)
        OPC_PAGE_WRITE: begin
          if (int'(arg) >= NUM_PAGES) bad_cmd = 1'b1;
          else if (lock_bits[ridx])   locked_hit = 1'b1;
          else                        kind = K_PWRITE;
        end
        OPC_LOCK_SET: begin
          if (region >= NUM_REGIONS) bad_cmd = 1'b1;
          else                       kind = K_LSET;
        end
        OPC_LOCK_CLR: begin
          if (region >= NUM_REGIONS) bad_cmd = 1'b1;
          else                       kind = K_LCLR;
        end
        OPC_LOCK_QUERY: kind = K_LQUERY;
        default:        bad_cmd = 1'b1;
      endcase
    end
  end

  // R1: a wrong key never yields an executable command
  always_comb begin
    if (cmd[31:24] != CMD_KEY)
      assert_bad_key_rejected_R1: assert (kind == K_NONE && bad_cmd && !locked_hit);
  end
endmodule

// File: rtl/fcl_lock_array.sv
module fcl_lock_array
  import fcl_pkg::*;
#(
  parameter int NUM_REGIONS = 40,
  localparam int RW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int NW = words_for(NUM_REGIONS),
  localparam int PW = $clog2(NW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic [RW-1:0]          idx,
  input  logic                   ptr_clr,
  input  logic                   ptr_inc,
  output logic [NUM_REGIONS-1:0] lock_bits,
  output logic [31:0]            word
);
  logic [PW-1:0]    ptr;
  logic [NW*32-1:0] padded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_bits <= '0;
    end else if (set_en) begin
      lock_bits[idx] <= 1'b1;
    end else if (clr_en) begin
      lock_bits[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ptr <= '0;
    else if (ptr_clr)                    ptr <= '0;
    else if (ptr_inc && ptr < PW'(NW))   ptr <= ptr + 1'b1;
  end

  always_comb begin
    padded = '0;
    padded[NUM_REGIONS-1:0] = lock_bits;
  end

  assign word = (ptr < PW'(NW)) ? padded[int'(ptr)*32 +: 32] : 32'h0;

  assert_lock_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(lock_bits));

  assert_ptr_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (word == padded[31:0]));
endmodule

// File: rtl/fcl_flash_model.sv
module fcl_flash_model #(
  parameter int NUM_PAGES = 80,
  localparam int PAW = $clog2(NUM_PAGES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [PAW-1:0] waddr,
  input  logic [31:0]    wdata,
  input  logic [PAW-1:0] raddr,
  output logic [31:0]    rdata
);
  logic [31:0] mem [NUM_PAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++) mem[i] <= 32'hFFFF_FFFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (int'(raddr) < NUM_PAGES) ? mem[raddr] : 32'h0;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcl_pkg::*;
#(
  parameter int NUM_PAGES = 80,
  parameter int PAGES_PER_REGION = 2,
  parameter int NUM_REGIONS = 40,
  parameter int PROG_CYCLES = 6,
  parameter int LOCK_CYCLES = 2,
  localparam int PAW = $clog2(NUM_PAGES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [31:0]    cmd_word,
  input  logic [31:0]    wbuf,
  input  logic           mode_wr,
  input  logic           mode_irq_en,
  input  logic           stat_rd,
  output logic [7:0]     stat_word,
  input  logic           res_rd,
  output logic [31:0]    res_word,
  input  logic           vfy_fail,
  input  logic [PAW-1:0] fl_raddr,
  output logic [31:0]    fl_rdata,
  output logic           fl_rvalid,
  output logic           irq
);
  localparam int RW   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int MAXC = (PROG_CYCLES > LOCK_CYCLES) ? PROG_CYCLES : LOCK_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  cmd_kind_e             kind, kind_q;
  logic                  bad_cmd, locked_hit;
  logic [NUM_REGIONS-1:0] lock_bits;
  logic                  busy_q;
  logic [CW-1:0]         cnt_q;
  logic [15:0]           page_q;
  logic [31:0]           data_q;
  logic                  done_q, cmd_err_q, lock_err_q, flash_err_q, irq_en_q;
  logic                  ready;

  // named internal events
  logic cmd_take, accept_evt, reject_cmd, reject_lock, done_pulse;
  logic lock_set, lock_clr, fl_we, ptr_clr;
  logic [RW-1:0] region_q;

  assign ready       = !busy_q;
  assign cmd_take    = cmd_wr && ready;
  assign accept_evt  = cmd_take && (kind != K_NONE);
  assign reject_cmd  = cmd_take && bad_cmd;
  assign reject_lock = cmd_take && locked_hit;
  assign done_pulse  = busy_q && (cnt_q == '0);
  assign region_q    = RW'(region_of(int'(page_q), PAGES_PER_REGION));
  assign lock_set    = done_pulse && (kind_q == K_LSET);
  assign lock_clr    = done_pulse && (kind_q == K_LCLR);
  assign fl_we       = done_pulse && (kind_q == K_PWRITE);
  assign ptr_clr     = accept_evt && (kind == K_LQUERY);

  fcl_decode #(
    .NUM_PAGES(NUM_PAGES), .PAGES_PER_REGION(PAGES_PER_REGION), .NUM_REGIONS(NUM_REGIONS)
  ) u_decode (
    .cmd(cmd_word), .lock_bits(lock_bits),
    .kind(kind), .bad_cmd(bad_cmd), .locked_hit(locked_hit)
  );

  fcl_lock_array #(.NUM_REGIONS(NUM_REGIONS)) u_locks (
    .clk(clk), .rst_n(rst_n), .set_en(lock_set), .clr_en(lock_clr), .idx(region_q),
    .ptr_clr(ptr_clr), .ptr_inc(res_rd), .lock_bits(lock_bits), .word(res_word)
  );

  fcl_flash_model #(.NUM_PAGES(NUM_PAGES)) u_array (
    .clk(clk), .rst_n(rst_n), .we(fl_we), .waddr(page_q[PAW-1:0]), .wdata(data_q),
    .raddr(fl_raddr), .rdata(fl_rdata)
  );

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= K_NONE;
      page_q <= '0;
      data_q <= '0;
    end else if (accept_evt) begin
      busy_q <= 1'b1;
      cnt_q  <= (kind == K_PWRITE) ? CW'(PROG_CYCLES - 1) : CW'(LOCK_CYCLES - 1);
      kind_q <= kind;
      page_q <= cmd_word[23:8];
      data_q <= wbuf;
    end else if (done_pulse) begin
      busy_q <= 1'b0;
      kind_q <= K_NONE;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // status flags: events win over read-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q      <= 1'b0;
      cmd_err_q   <= 1'b0;
      lock_err_q  <= 1'b0;
      flash_err_q <= 1'b0;
      irq_en_q    <= 1'b0;
    end else begin
      done_q      <= (done_q && !stat_rd) || done_pulse;
      cmd_err_q   <= (cmd_err_q && !stat_rd) || reject_cmd;
      lock_err_q  <= (lock_err_q && !stat_rd) || reject_lock;
      flash_err_q <= (flash_err_q && !stat_rd) || (done_pulse && vfy_fail);
      if (mode_wr) irq_en_q <= mode_irq_en;
    end
  end

  assign stat_word = {3'b000, flash_err_q, lock_err_q, cmd_err_q, done_q, ready};
  assign irq       = done_q && irq_en_q;
  assign fl_rvalid = !(busy_q && kind_q == K_PWRITE);

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !stat_word[0]);
  assert_done_restores_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> stat_word[0]);
  assert_done_raises_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && irq_en_q && !mode_wr) |=> irq);
  assert_lock_reject_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject_lock |=> !fl_we);
  assert_reads_open_in_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_set || lock_clr) |-> fl_rvalid);
  assert_stat_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_take) |=> !stat_word[2]);
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int NP = 80, PPR = 2, NR = 40, PROG = 6, LOCKC = 2;
  localparam int NWORDS = (NR + 31) / 32;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, mode_wr = 0, mode_irq_en = 0, stat_rd = 0, res_rd = 0, vfy_fail = 0;
  logic [31:0] cmd_word = 0, wbuf = 0;
  logic [6:0] fl_raddr = 0;
  logic [7:0] stat_word;
  logic [31:0] res_word, fl_rdata;
  logic fl_rvalid, irq;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk, .rst_n, .cmd_wr, .cmd_word, .wbuf, .mode_wr, .mode_irq_en, .stat_rd,
    .stat_word, .res_rd, .res_word, .vfy_fail, .fl_raddr, .fl_rdata, .fl_rvalid, .irq
  );

  // ---------------- reference model ----------------
  bit m_lock [NR];
  logic [31:0] m_mem [NP];
  bit m_busy, m_done, m_cerr, m_lerr, m_ferr, m_ien;
  int m_cnt, m_kind, m_page, m_ptr;   // kind: 0 none 1 write 2 set 3 clr 4 query
  logic [31:0] m_data;

  function automatic logic [31:0] m_word(int k);
    logic [31:0] w = 0;
    for (int n = 0; n < 32; n++)
      if (32*k + n < NR) w[n] = m_lock[32*k + n];
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_lock[i]) m_lock[i] = 0;
      foreach (m_mem[i]) m_mem[i] = 32'hFFFF_FFFF;
      m_busy = 0; m_done = 0; m_cerr = 0; m_lerr = 0; m_ferr = 0; m_ien = 0;
      m_cnt = 0; m_kind = 0; m_page = 0; m_ptr = 0; m_data = 0;
    end else begin
      bit was_busy, fin, bad, lhit;
      int k, arg;
      was_busy = m_busy;
      fin = m_busy && m_cnt == 0;
      bad = 0; lhit = 0; k = 0;
      arg = int'(cmd_word[23:8]);
      if (cmd_wr && !was_busy) begin
        if (cmd_word[31:24] != 8'hA5) bad = 1;
        else case (cmd_word[7:0])
          8'h03: if (arg >= NP) bad = 1; else if (m_lock[arg / PPR]) lhit = 1; else k = 1;
          8'h08: if (arg / PPR >= NR) bad = 1; else k = 2;
          8'h09: if (arg / PPR >= NR) bad = 1; else k = 3;
          8'h0A: k = 4;
          default: bad = 1;
        endcase
      end
      if (stat_rd) begin m_done = 0; m_cerr = 0; m_lerr = 0; m_ferr = 0; end
      if (bad) m_cerr = 1;
      if (lhit) m_lerr = 1;
      if (mode_wr) m_ien = mode_irq_en;
      if (res_rd && m_ptr < NWORDS) m_ptr++;
      if (fin) begin
        m_done = 1;
        if (vfy_fail) m_ferr = 1;
        if (m_kind == 1) m_mem[m_page] = m_data;
        if (m_kind == 2) m_lock[m_page / PPR] = 1;
        if (m_kind == 3) m_lock[m_page / PPR] = 0;
        m_busy = 0; m_kind = 0;
      end else if (m_busy) m_cnt--;
      if (k != 0) begin
        m_busy = 1; m_kind = k; m_page = arg; m_data = wbuf;
        m_cnt = (k == 1) ? PROG - 1 : LOCKC - 1;
        if (k == 4) m_ptr = 0;
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "ready", 32'(stat_word[0]), 32'(!m_busy));
      chk("R3", "done event", 32'(stat_word[1]), 32'(m_done));
      chk("R3", "irq", 32'(irq), 32'(m_done && m_ien));
      chk("R1", "cmd_err", 32'(stat_word[2]), 32'(m_cerr));
      chk("R6", "lock_err", 32'(stat_word[3]), 32'(m_lerr));
      chk("R9", "flash_err", 32'(stat_word[4]), 32'(m_ferr));
      chk("R8", "res_word", res_word, (m_ptr < NWORDS) ? m_word(m_ptr) : 32'h0);
      chk("R10", "fl_rvalid", 32'(fl_rvalid), 32'(!(m_busy && m_kind == 1)));
      chk("R7", "fl_rdata", fl_rdata, m_mem[fl_raddr]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(posedge clk); #2; endtask

  task automatic issue(logic [7:0] key, logic [7:0] op, int arg, logic [31:0] d);
    tick();
    cmd_wr = 1; cmd_word = {key, 16'(arg), op}; wbuf = d;
    tick();
    cmd_wr = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stat_word[0]) break;
    end
  endtask

  task automatic read_stat();
    tick(); stat_rd = 1; tick(); stat_rd = 0;
  endtask

  task automatic read_res(string tag, logic [31:0] exp);
    tick(); res_rd = 1;
    @(negedge clk); chk(tag, "result word", res_word, exp);
    tick(); res_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk("R12", "status after reset", 32'(stat_word), 32'h01);
    chk("R12", "irq after reset", 32'(irq), 0);
    chk("R12", "lock word0 after reset", res_word, 0);

    tick(); mode_wr = 1; mode_irq_en = 1; tick(); mode_wr = 0;

    // R1: wrong key
    issue(8'h5A, 8'h08, 5, 0);
    @(negedge clk);
    chk("R1", "status after bad key", 32'(stat_word), 32'h05);
    read_stat();
    @(negedge clk);
    chk("R11", "status after read-to-clear", 32'(stat_word), 32'h01);

    // R4 + R2: lock regions 2, 35, 39; a clear issued while busy is ignored
    issue(8'hA5, 8'h08, 5, 0);
    tick(); cmd_wr = 1; cmd_word = {8'hA5, 16'd5, 8'h09}; tick(); cmd_wr = 0;
    wait_ready();
    chk("R3", "irq after lock-set", 32'(irq), 1);
    issue(8'hA5, 8'h08, 70, 0); wait_ready();
    issue(8'hA5, 8'h08, 79, 0); wait_ready();
    issue(8'hA5, 8'h0A, 1234, 0); wait_ready();
    read_res("R4", 32'h0000_0004);
    read_res("R8", 32'h0000_0088);
    read_res("R8", 32'h0);
    read_res("R8", 32'h0);
    issue(8'hA5, 8'h0A, 0, 0); wait_ready();
    read_res("R8", 32'h0000_0004);

    // R5: out-of-range and unknown opcodes
    read_stat();
    issue(8'hA5, 8'h08, 80, 0);
    @(negedge clk); chk("R5", "region out of range", 32'(stat_word), 32'h05);
    issue(8'hA5, 8'h77, 0, 0);
    issue(8'hA5, 8'h03, 80, 0);
    read_stat();

    // R6: write to locked page
    fl_raddr = 4;
    issue(8'hA5, 8'h03, 4, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R6", "lock reject status", 32'(stat_word), 32'h09);
    chk("R6", "locked page untouched", fl_rdata, 32'hFFFF_FFFF);
    read_stat();

    // R7 + R10: page write blocks reads, then stores data
    fl_raddr = 10;
    issue(8'hA5, 8'h03, 10, 32'h1234_5678);
    @(negedge clk); chk("R10", "reads blocked in write", 32'(fl_rvalid), 0);
    wait_ready();
    chk("R7", "page written", fl_rdata, 32'h1234_5678);

    // R9: unlock region 2, write page 4 with verify failure; irq disabled
    tick(); mode_wr = 1; mode_irq_en = 0; tick(); mode_wr = 0;
    issue(8'hA5, 8'h09, 4, 0); wait_ready();
    vfy_fail = 1; fl_raddr = 4;
    issue(8'hA5, 8'h03, 4, 32'hCAFE_0004); wait_ready();
    vfy_fail = 0;
    chk("R9", "flash error", 32'(stat_word[4]), 1);
    chk("R3", "irq masked", 32'(irq), 0);
    chk("R7", "unlocked page written", fl_rdata, 32'hCAFE_0004);
    repeat (4) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule